// File: doc/BRIEF.md
# Flash Page Assembly Buffer

This block stages the data for one flash page program. Load commands arrive on a simple write port. Each load carries either a 64-bit double-word or a 32-bit word. The block ignores the bus address of a load and places the data at a position taken from its own fill counter. It computes a SEC-DED check code for every 64-bit slot and keeps that code beside the data. The programming engine reads the finished page, data and code together, through an indexed read port.

A page-start pulse rewinds the fill counter and forgets which transfer width has been used, but it leaves the stored data alone. A commit that follows a page start with no loads in between therefore reprograms the previous pattern unchanged. The status outputs report three things: a completely filled page, a mix of word and double-word loads, and loads beyond the end of the page. A fourth flag marks a commit of a page that was only partly filled. The error flags hold until a clear pulse.

Top module: `page_asm_buf`

## Requirements
- R1: After reset, buf_full and the three error flags are low, and every slot reads as zero data with a zero check code.
- R2: A double-word load goes to the slot given by the fill counter. The counter starts at slot 0 after a page start and advances by one slot per load. ld_addr has no effect on placement.
- R3: In word mode, the first word of a slot goes to bits 31:0 and the second word goes to bits 63:32. A word uses ld_data[31:0]. Each half is written without changing the other half.
- R4: The 8-bit check code works as follows. Data bit d takes the d-th codeword position among 1..71 that is not a power of two, counted in ascending order. Code bit k (k=0..6) sits at position 2^k and makes the XOR of all set-bit positions zero. Code bit 7 makes the parity of the data and all code bits even. The code is written with every double-word load, and with the upper word of a pair computed over the new upper word and the stored lower word. A lower-word load leaves the code unchanged.
- R5: buf_full rises after 32 double-word loads or 64 word loads. It stays high until a page start, and it is low in the cycle after a page start.
- R6: A load of the other width than the first load since the page start sets err_mix. That load is discarded: nothing is written and the counter does not move.
- R7: A load of the tracked width while the page is full sets err_ovf and writes nothing.
- R8: A commit sets err_part when between one and 63 words are loaded. A commit on a full page, or on a page with nothing loaded since the page start (pattern reuse), leaves err_part unchanged.
- R9: A page start keeps all stored data. A load in the same cycle as a page start is dropped.
- R10: The error flags are sticky until clr_status. An error event in the same cycle as clr_status wins, and its flag reads high afterwards.
- R11: rd_data and rd_ecc show slot rd_idx combinationally from storage. A load is visible there from the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_page | input | 1 | Page start: rewinds the fill counter and clears width tracking |
| clr_status | input | 1 | Clears the sticky error flags |
| ld_valid | input | 1 | Load command strobe |
| ld_dword | input | 1 | 1 = 64-bit load, 0 = 32-bit load |
| ld_addr | input | 32 | Bus address of the load (ignored) |
| ld_data | input | 64 | Load data; a word uses bits 31:0 |
| commit | input | 1 | Page program request |
| rd_idx | input | 5 | Slot selected for reading |
| rd_data | output | 64 | Data of the selected slot |
| rd_ecc | output | 8 | Check code of the selected slot |
| buf_full | output | 1 | All slots loaded |
| err_mix | output | 1 | Sticky: word and double-word loads mixed |
| err_ovf | output | 1 | Sticky: load beyond the last position |
| err_part | output | 1 | Sticky: commit of a partly filled page |

## Verification
Every status flag is registered. Its response to a command is due one clock after the edge that takes the command. The read port has no register of its own, so a load appears there from the cycle after its edge. The bench applies each command on a falling edge and holds it through one rising edge. It samples flags and read data at the next falling edge, which is exactly the cycle each result is due. The check code is judged by decoding the stored codeword and requiring a zero syndrome and even parity.

// File: rtl/pab_pkg.sv
package pab_pkg;

    typedef enum logic [1:0] {
        FILL_NONE  = 2'd0,
        FILL_WORD  = 2'd1,
        FILL_DWORD = 2'd2
    } fill_mode_e;

    // number of Hamming check bits for a data width
    function automatic int unsigned ham_bits(int unsigned dw);
        for (int unsigned p = 1; p < 32; p++) begin
            if ((32'd1 << p) >= dw + p + 1) return p;
        end
        return 32;
    endfunction

    // codeword position of data bit d (positions that are not powers of two)
    function automatic int unsigned data_pos(int unsigned d);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned p = 1; p < 1024; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == d) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/pab_secded_enc.sv
module pab_secded_enc #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned HAM_W = pab_pkg::ham_bits(DATA_W),
    localparam int unsigned ECC_W = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data,
    output logic [ECC_W-1:0]  ecc
);

    logic [HAM_W-1:0] term [DATA_W];
    logic [HAM_W-1:0] ham;

    // each set data bit contributes its codeword position
    for (genvar d = 0; d < DATA_W; d++) begin : g_term
        localparam int unsigned POS = pab_pkg::data_pos(d);
        assign term[d] = data[d] ? HAM_W'(POS) : '0;
    end

    always_comb begin
        ham = '0;
        for (int d = 0; d < DATA_W; d++) begin
            ham = ham ^ term[d];
        end
        ecc = {(^data) ^ (^ham), ham};
    end

endmodule

// File: rtl/pab_fill_ctrl.sv
module pab_fill_ctrl #(
    parameter int unsigned UNITS = 32,
    localparam int unsigned WORDS  = 2 * UNITS,
    localparam int unsigned PTR_W  = $clog2(WORDS + 1),
    localparam int unsigned SLOT_W = $clog2(UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_page,
    input  logic              clr_status,
    input  logic              ld_valid,
    input  logic              ld_dword,
    input  logic              commit,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              full,
    output logic              err_mix,
    output logic              err_ovf,
    output logic              err_part
);
    import pab_pkg::*;

    localparam logic [PTR_W-1:0] FULL_PTR = PTR_W'(WORDS);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        fill_mode_e       mode;
        logic             mix;
        logic             ovf;
        logic             part;
    } fill_state_t;

    fill_state_t s_d, s_q;
    fill_mode_e  req_mode;

    always_comb begin
        s_d      = s_q;
        wr_lo    = 1'b0;
        wr_hi    = 1'b0;
        req_mode = ld_dword ? FILL_DWORD : FILL_WORD;
        full     = (s_q.ptr == FULL_PTR);
        wr_slot  = SLOT_W'(s_q.ptr >> 1);

        if (clr_status) begin
            s_d.mix  = 1'b0;
            s_d.ovf  = 1'b0;
            s_d.part = 1'b0;
        end

        if (enter_page) begin
            s_d.ptr  = '0;
            s_d.mode = FILL_NONE;
        end else begin
            if (ld_valid) begin
                if (s_q.mode != FILL_NONE && s_q.mode != req_mode) begin
                    s_d.mix = 1'b1;
                end else if (full) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.mode = req_mode;
                    if (ld_dword) begin
                        wr_lo   = 1'b1;
                        wr_hi   = 1'b1;
                        s_d.ptr = s_q.ptr + PTR_W'(2);
                    end else begin
                        wr_lo   = ~s_q.ptr[0];
                        wr_hi   = s_q.ptr[0];
                        s_d.ptr = s_q.ptr + PTR_W'(1);
                    end
                end
            end
            if (commit && s_q.ptr != '0 && !full) begin
                s_d.part = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ptr: '0, mode: FILL_NONE, mix: 1'b0, ovf: 1'b0, part: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign err_mix  = s_q.mix;
    assign err_ovf  = s_q.ovf;
    assign err_part = s_q.part;

endmodule

// File: rtl/pab_slot_store.sv
module pab_slot_store #(
    parameter int unsigned UNITS  = 32,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ECC_W  = 8,
    localparam int unsigned HALF_W = DATA_W / 2,
    localparam int unsigned SLOT_W = $clog2(UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ECC_W-1:0]  wr_ecc,
    output logic [HALF_W-1:0] cur_lo,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [ECC_W-1:0]  rd_ecc
);

    typedef struct packed {
        logic [UNITS-1:0][DATA_W-1:0] data;
        logic [UNITS-1:0][ECC_W-1:0]  ecc;
    } store_t;

    store_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_lo) begin
            m_d.data[wr_slot][HALF_W-1:0] = wr_data[HALF_W-1:0];
        end
        if (wr_hi) begin
            m_d.data[wr_slot][DATA_W-1:HALF_W] = wr_data[DATA_W-1:HALF_W];
            m_d.ecc[wr_slot]                   = wr_ecc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign cur_lo  = m_q.data[wr_slot][HALF_W-1:0];
    assign rd_data = m_q.data[rd_idx];
    assign rd_ecc  = m_q.ecc[rd_idx];

endmodule

// File: rtl/page_asm_buf.sv
module page_asm_buf #(
    parameter int unsigned UNITS  = 32,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned HALF_W = DATA_W / 2,
    localparam int unsigned HAM_W  = pab_pkg::ham_bits(DATA_W),
    localparam int unsigned ECC_W  = HAM_W + 1,
    localparam int unsigned SLOT_W = $clog2(UNITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_page,
    input  logic              clr_status,
    input  logic              ld_valid,
    input  logic              ld_dword,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              commit,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [ECC_W-1:0]  rd_ecc,
    output logic              buf_full,
    output logic              err_mix,
    output logic              err_ovf,
    output logic              err_part
);

    logic [SLOT_W-1:0] wr_slot;
    logic              wr_lo;
    logic              wr_hi;
    logic [HALF_W-1:0] cur_lo;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] enc_in;
    logic [ECC_W-1:0]  enc_out;
    logic              unused_addr;

    // placement comes from the fill counter only
    assign unused_addr = ^ld_addr;

    pab_fill_ctrl #(.UNITS(UNITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_page (enter_page),
        .clr_status (clr_status),
        .ld_valid   (ld_valid),
        .ld_dword   (ld_dword),
        .commit     (commit),
        .wr_slot    (wr_slot),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .full       (buf_full),
        .err_mix    (err_mix),
        .err_ovf    (err_ovf),
        .err_part   (err_part)
    );

    // a word is replicated onto both halves; the half enables pick one
    assign wr_data = ld_dword ? ld_data : {ld_data[HALF_W-1:0], ld_data[HALF_W-1:0]};
    // upper word completes the pair with the stored lower word
    assign enc_in  = ld_dword ? ld_data : {ld_data[HALF_W-1:0], cur_lo};

    pab_secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data (enc_in),
        .ecc  (enc_out)
    );

    pab_slot_store #(.UNITS(UNITS), .DATA_W(DATA_W), .ECC_W(ECC_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_slot (wr_slot),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .wr_ecc  (enc_out),
        .cur_lo  (cur_lo),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rd_ecc  (rd_ecc)
    );

endmodule

// File: rtl/pab_chk.sv
module pab_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ECC_W  = 8,
    parameter int unsigned SLOT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter_page,
    input logic              clr_status,
    input logic              ld_valid,
    input logic              commit,
    input logic [SLOT_W-1:0] rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic [ECC_W-1:0]  rd_ecc,
    input logic              buf_full,
    input logic              err_mix,
    input logic              err_ovf,
    input logic              err_part
);

    assert_enter_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enter_page |=> !buf_full);

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !enter_page) |=> buf_full);

    assert_full_load_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && ld_valid && !enter_page) |=> (err_ovf || err_mix));

    assert_sticky_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf && !clr_status) |=> err_ovf);

    assert_sticky_mix_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mix && !clr_status) |=> err_mix);

    assert_sticky_part_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_part && !clr_status) |=> err_part);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !ld_valid && !commit) |=> (!err_mix && !err_ovf && !err_part));

    assert_store_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> (!$stable(rd_idx) || ($stable(rd_data) && $stable(rd_ecc))));

endmodule

bind page_asm_buf pab_chk #(
    .DATA_W (DATA_W),
    .ECC_W  (ECC_W),
    .SLOT_W (SLOT_W)
) u_pab_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_page (enter_page),
    .clr_status (clr_status),
    .ld_valid   (ld_valid),
    .commit     (commit),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .rd_ecc     (rd_ecc),
    .buf_full   (buf_full),
    .err_mix    (err_mix),
    .err_ovf    (err_ovf),
    .err_part   (err_part)
);

// File: tb/tb_page_asm_buf.sv
module tb_page_asm_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_page = 1'b0;
    logic        clr_status = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_dword = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [63:0] ld_data = '0;
    logic        commit = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [7:0]  rd_ecc;
    logic        buf_full, err_mix, err_ovf, err_part;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    page_asm_buf dut (
        .clk(clk), .rst_n(rst_n), .enter_page(enter_page), .clr_status(clr_status),
        .ld_valid(ld_valid), .ld_dword(ld_dword), .ld_addr(ld_addr), .ld_data(ld_data),
        .commit(commit), .rd_idx(rd_idx), .rd_data(rd_data), .rd_ecc(rd_ecc),
        .buf_full(buf_full), .err_mix(err_mix), .err_ovf(err_ovf), .err_part(err_part)
    );

    typedef struct packed {
        logic        enter;
        logic        clr;
        logic        ld;
        logic        dw;
        logic        cmt;
        logic [63:0] data;
        logic [3:0]  exp; // full, mix, ovf, part
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,                  4'b0000}, // enter
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 4'b0000}, // dword
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h5555,               4'b0100}, // R6 mix
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                  4'b0101}, // R8 partial
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0,                  4'b0000}, // R10 clear
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h5555,               4'b0100}, // R10 set wins
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,                  4'b0100}, // R10 sticky
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0,                  4'b0000},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h5555,               4'b0000}, // word first
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h7777,               4'b0100}, // R6 mix
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0,                  4'b0000},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                  4'b0000}, // R8 reuse
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h9999,               4'b0000},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                  4'b0001}  // R8 partial
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // apply one command on a falling edge, hold through one rising edge
    task automatic cmd(input logic en, input logic cl, input logic ld, input logic dw,
                       input logic [31:0] ad, input logic [63:0] dt, input logic cm);
        enter_page = en; clr_status = cl; ld_valid = ld; ld_dword = dw;
        ld_addr = ad; ld_data = dt; commit = cm;
        @(negedge clk);
        enter_page = 0; clr_status = 0; ld_valid = 0; ld_dword = 0; commit = 0;
    endtask

    // decode the stored codeword: zero syndrome and even parity
    function automatic bit ecc_ok(input logic [63:0] d, input logic [7:0] e);
        int syn;
        int di;
        bit b;
        syn = 0;
        di = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) == 0) begin
                b = 1'b0;
                for (int k = 0; k < 7; k++) if (p == (1 << k)) b = e[k];
            end else begin
                b = d[di];
                di++;
            end
            if (b) syn = syn ^ p;
        end
        return (syn == 0) && (((^d) ^ (^e)) == 1'b0);
    endfunction

    function automatic logic [63:0] pat(input int i);
        return {32'hA500_0000 + i, 32'h0F0F_0000 ^ (i * 77)};
    endfunction

    task automatic rd(input int idx);
        rd_idx = 5'(idx);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] old_ecc;
        logic [63:0] old_d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "status after reset", {60'h0, buf_full, err_mix, err_ovf, err_part}, 64'h0);
        rd(0);
        chk("R1", "slot0 data after reset", rd_data, 64'h0);
        chk("R1", "slot0 ecc after reset", {56'h0, rd_ecc}, 64'h0);

        // table of stimulus and expected flags (R6, R8, R10)
        for (int v = 0; v < 14; v++) begin
            cmd(VEC[v].enter, VEC[v].clr, VEC[v].ld, VEC[v].dw, 32'h100 * v, VEC[v].data, VEC[v].cmt);
            chk("R6/R8/R10", $sformatf("table row %0d flags", v),
                {60'h0, buf_full, err_mix, err_ovf, err_part}, {60'h0, VEC[v].exp});
        end

        // R2 R5: fill the page with double-words at scattered addresses
        cmd(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 32; i++) begin
            cmd(0, 0, 1, 1, 32'hFFF0 - 32'(i * 24), pat(i), 0);
            if (i == 30) chk("R5", "not full at 31 loads", {63'h0, buf_full}, 64'h0);
        end
        chk("R5", "full after 32 dword loads", {63'h0, buf_full}, 64'h1);
        for (int i = 0; i < 32; i++) begin
            rd(i);
            chk("R2", $sformatf("slot %0d data", i), rd_data, pat(i));
            chk("R4", $sformatf("slot %0d ecc decodes clean", i), {63'h0, ecc_ok(rd_data, rd_ecc)}, 64'h1);
        end

        // R8 commit on a full page
        cmd(0, 0, 0, 0, 0, 0, 1);
        chk("R8", "no partial flag on full commit", {63'h0, err_part}, 64'h0);

        // R7 overflow load is flagged and ignored
        cmd(0, 0, 1, 1, 0, 64'hDEAD_BEEF_DEAD_BEEF, 0);
        chk("R7", "overflow flag", {61'h0, err_mix, err_ovf, err_part}, 64'h2);
        rd(0);
        chk("R7", "slot0 untouched by overflow", rd_data, pat(0));
        rd(31);
        chk("R7", "slot31 untouched by overflow", rd_data, pat(31));

        // R5 R9 page start keeps data
        cmd(0, 1, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, 0, 0, 0);
        chk("R5", "not full after page start", {63'h0, buf_full}, 64'h0);
        rd(5);
        chk("R9", "slot5 kept over page start", rd_data, pat(5));

        // R9 load together with page start is dropped
        cmd(1, 0, 1, 1, 0, 64'h1111_1111_1111_1111, 0);
        rd(0);
        chk("R9", "load with page start dropped", rd_data, pat(0));
        old_ecc = rd_ecc;
        old_d = rd_data;

        // R3 R4 R11 word pair into slot 0
        cmd(0, 0, 1, 0, 32'h40, {32'hFFFF_FFFF, 32'h1111_2222}, 0);
        rd(0);
        chk("R3", "lower word placed", rd_data, {old_d[63:32], 32'h1111_2222});
        chk("R4", "ecc held after lower word", {56'h0, rd_ecc}, {56'h0, old_ecc});
        cmd(0, 0, 1, 0, 32'h40, {32'h0, 32'h3333_4444}, 0);
        rd(0);
        chk("R3", "upper word placed", rd_data, 64'h3333_4444_1111_2222);
        chk("R4", "ecc over word pair", {63'h0, ecc_ok(rd_data, rd_ecc)}, 64'h1);
        chk("R6", "no mix in word fill", {63'h0, err_mix}, 64'h0);

        // R5 word fill to 64
        for (int i = 2; i < 64; i++) begin
            cmd(0, 0, 1, 0, 0, {32'h0, 32'hC0DE_0000 + 32'(i)}, 0);
            if (i == 62) chk("R5", "not full at 63 words", {63'h0, buf_full}, 64'h0);
        end
        chk("R5", "full after 64 word loads", {63'h0, buf_full}, 64'h1);
        rd(31);
        chk("R3", "slot31 word pair", rd_data, {32'hC0DE_003F, 32'hC0DE_003E});
        chk("R4", "slot31 ecc", {63'h0, ecc_ok(rd_data, rd_ecc)}, 64'h1);
        cmd(0, 0, 0, 0, 0, 0, 1);
        chk("R8", "full word commit not partial", {63'h0, err_part}, 64'h0);
        cmd(0, 0, 1, 0, 0, 64'h5, 0);
        chk("R7", "word overflow flag", {63'h0, err_ovf}, 64'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule